// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Bank State Tracker

This block watches the command pins of a double-data-rate SDRAM on every rising clock edge. It turns the chip-select, row-strobe, column-strobe, write-enable and clock-enable levels into a single command code. It keeps a state machine for each bank and one for the device as a whole, and it judges every command against those states. A command that breaks the state rules is reported and has no other effect.

A controller model, a bus monitor or a protocol checker can use the block by placing it on the same command bus as the memory. The registered command code, one 3-bit state per bank, the device state and a one-cycle illegal flag all change on the clock edge that samples the command. The burst length, precharge time, mode-write time and refresh time are counted in clock cycles and set by parameters.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: While rst_n is low, and on the first edge after it goes low, every bank state is idle (0), the device state is normal (0), cmd_o is NOP (0) and illegal_o is 0. Reset also clears power-down and sets the remembered previous CKE level to low.
- R2: On each rising edge with CKE high and the device not powered down, the sampled pins {cs_n,ras_n,cas_n,we_n} are decoded. The codes are: 1xxx deselect=1, 0111 NOP=0, 0011 activate=2, 0101 read=3, 0100 write=4, 0010 precharge (precharge=5 when a10 is low, all-bank precharge=6 when a10 is high), 0001 refresh=7, 0000 mode write (8 when ba[0]=0, extended 9 when ba[0]=1), 0110 burst stop=10. The code appears on cmd_o after that same edge.
- R3: An activate is legal only when the device is normal and the bank selected by ba is idle. The bank then becomes active (1).
- R4: A read or write is legal only when the device is normal and the selected bank is active, reading or writing. The bank shows reading (2) or writing (3) for BURST_CYC cycles and then returns to active.
- R5: Precharge is legal whenever the device is normal. Each targeted bank that is active, reading or writing shows precharging (4) for PRE_CYC cycles and then idle. Targeted banks that are idle or already precharging keep their state and timing.
- R6: A mode write or extended mode write is legal only when all banks are idle, the device is normal and CKE was high at the previous edge. The device then shows mode-set (1) for MRD_CYC cycles.
- R7: At most one bank is bursting. A legal read or write to one bank returns any bank reading or writing elsewhere to active.
- R8: Refresh is legal only when all banks are idle and the device is normal. The device then shows refresh (2) for RFC_CYC cycles.
- R9: Burst stop is legal only while a bank is reading, and that bank returns to active. With no read in progress, including during a write burst, it is illegal.
- R10: CKE low outside power-down is a power-down entry (code 11). It is legal only when all banks are idle and the device is normal, and the device then shows power-down (3). In power-down, CKE low decodes as NOP whatever the other pins are. CKE high decodes as exit (12), and the device returns to normal.
- R11: Deselect and NOP are never illegal and change no state. A burst in progress keeps counting through them.
- R12: illegal_o is high for the cycle after each edge that sampled an illegal command, and that command changes no bank or device state. While the device is in mode-set or refresh, every command except NOP, deselect and power-down exit is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge samples |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable pin level |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Address bit 10, chooses all-bank precharge |
| cmd_o | output | 4 | Decoded command code (R2) |
| illegal_o | output | 1 | Pulse for an illegal command |
| bank_state_o | output | 3*BANKS | Bank state, bank g in bits [3g+2:3g] |
| dev_state_o | output | 2 | Device state: normal, mode-set, refresh, power-down |

## Verification
The hardest case to reach from the pins is a power-down entry on the same edge where the last bank finishes precharging. The judgment has to use the state from before that edge. The stimulus reaches it by issuing a single-bank precharge, then an all-bank precharge one cycle later, then counting out the precharge time exactly so that CKE falls on that edge. A second hard case is a burst stop issued while a different bank is still in its write burst. It is reached by opening two banks and starting a write on one of them.

// File: rtl/ddr_cmd_pkg.sv
`timescale 1ns/1ps
package ddr_cmd_pkg;
   typedef enum logic [3:0] {
      CMD_NOP     = 4'd0,
      CMD_DESEL   = 4'd1,
      CMD_ACT     = 4'd2,
      CMD_READ    = 4'd3,
      CMD_WRITE   = 4'd4,
      CMD_PRE     = 4'd5,
      CMD_PREALL  = 4'd6,
      CMD_REFRESH = 4'd7,
      CMD_MODE    = 4'd8,
      CMD_EXTMODE = 4'd9,
      CMD_BSTOP   = 4'd10,
      CMD_PDENTER = 4'd11,
      CMD_PDEXIT  = 4'd12
   } cmd_e;

   typedef enum logic [2:0] {
      BK_IDLE    = 3'd0,
      BK_ACTIVE  = 3'd1,
      BK_READING = 3'd2,
      BK_WRITING = 3'd3,
      BK_PRECHG  = 3'd4
   } bank_e;

   typedef enum logic [1:0] {
      DV_NORMAL  = 2'd0,
      DV_MODESET = 2'd1,
      DV_REFRESH = 2'd2,
      DV_PWRDN   = 2'd3
   } dev_e;
endpackage

// File: rtl/ddr_cmd_decode.sv
`timescale 1ns/1ps
module ddr_cmd_decode
   import ddr_cmd_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   input  logic cke,
   input  logic ba0,
   input  logic a10,
   input  logic pd_i,
   output cmd_e cmd_o
);
   always_comb begin
      cmd_o = CMD_NOP;
      if (pd_i) begin
         // R10: in power-down only CKE matters
         cmd_o = cke ? CMD_PDEXIT : CMD_NOP;
      end else if (!cke) begin
         cmd_o = CMD_PDENTER;
      end else if (cs_n) begin
         cmd_o = CMD_DESEL;
      end else begin
         unique case ({ras_n, cas_n, we_n})
            3'b111: cmd_o = CMD_NOP;
            3'b011: cmd_o = CMD_ACT;
            3'b101: cmd_o = CMD_READ;
            3'b100: cmd_o = CMD_WRITE;
            3'b010: cmd_o = a10 ? CMD_PREALL : CMD_PRE;
            3'b001: cmd_o = CMD_REFRESH;
            3'b000: cmd_o = ba0 ? CMD_EXTMODE : CMD_MODE;
            3'b110: cmd_o = CMD_BSTOP;
            default: cmd_o = CMD_NOP;
         endcase
      end
   end
endmodule

// File: rtl/ddr_cmd_judge.sv
`timescale 1ns/1ps
module ddr_cmd_judge
   import ddr_cmd_pkg::*;
#(
   parameter  int BANKS = 4,
   localparam int BA_W  = $clog2(BANKS)
) (
   input  cmd_e             cmd_i,
   input  logic [BA_W-1:0]  ba_i,
   input  bank_e            st_i [BANKS],
   input  dev_e             dev_i,
   input  logic             cke_prev_i,
   output logic             legal_o
);
   logic all_idle, any_read, dev_ok;
   bank_e sel_st;

   always_comb begin
      all_idle = 1'b1;
      any_read = 1'b0;
      for (int b = 0; b < BANKS; b++) begin
         if (st_i[b] != BK_IDLE)    all_idle = 1'b0;
         if (st_i[b] == BK_READING) any_read = 1'b1;
      end
   end

   assign sel_st = st_i[ba_i];
   assign dev_ok = (dev_i == DV_NORMAL);

   always_comb begin
      unique case (cmd_i)
         CMD_NOP, CMD_DESEL, CMD_PDEXIT: legal_o = 1'b1;
         CMD_ACT:                legal_o = dev_ok && (sel_st == BK_IDLE);
         CMD_READ, CMD_WRITE:    legal_o = dev_ok &&
                                   (sel_st inside {BK_ACTIVE, BK_READING, BK_WRITING});
         CMD_PRE, CMD_PREALL:    legal_o = dev_ok;
         CMD_REFRESH:            legal_o = dev_ok && all_idle;
         CMD_MODE, CMD_EXTMODE:  legal_o = dev_ok && all_idle && cke_prev_i;
         CMD_BSTOP:              legal_o = dev_ok && any_read;
         CMD_PDENTER:            legal_o = dev_ok && all_idle;
         default:                legal_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/ddr_bank_fsm.sv
`timescale 1ns/1ps
module ddr_bank_fsm
   import ddr_cmd_pkg::*;
#(
   parameter  int BURST_CYC = 4,
   parameter  int PRE_CYC   = 3,
   localparam int TMAX      = (BURST_CYC > PRE_CYC) ? BURST_CYC : PRE_CYC,
   localparam int TW        = $clog2(TMAX + 1)
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  act_i,
   input  logic  rd_i,
   input  logic  wr_i,
   input  logic  pre_i,
   input  logic  end_i,
   output bank_e st_o
);
   bank_e st_q, st_d;
   logic [TW-1:0] t_q, t_d;

   generate
      if (BURST_CYC < 1 || PRE_CYC < 1) begin : g_bad_cyc
         $error("ddr_bank_fsm: cycle counts must be at least 1");
      end
   endgenerate

   always_comb begin
      st_d = st_q;
      t_d  = t_q;
      unique case (st_q)
         BK_READING, BK_WRITING: if (t_q == '0) st_d = BK_ACTIVE; else t_d = t_q - 1'b1;
         BK_PRECHG:              if (t_q == '0) st_d = BK_IDLE;   else t_d = t_q - 1'b1;
         default: ;
      endcase
      if (act_i) begin
         st_d = BK_ACTIVE;
      end else if (rd_i) begin
         st_d = BK_READING;
         t_d  = TW'(BURST_CYC - 1);
      end else if (wr_i) begin
         st_d = BK_WRITING;
         t_d  = TW'(BURST_CYC - 1);
      end else if (pre_i && (st_q inside {BK_ACTIVE, BK_READING, BK_WRITING})) begin
         st_d = BK_PRECHG;
         t_d  = TW'(PRE_CYC - 1);
      end else if (end_i && (st_q inside {BK_READING, BK_WRITING})) begin
         st_d = BK_ACTIVE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= BK_IDLE;
         t_q  <= '0;
      end else begin
         st_q <= st_d;
         t_q  <= t_d;
      end
   end

   assign st_o = st_q;

   // R3: an idle bank can only stay idle or open a row
   a_r3_idle_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == BK_IDLE) |=> (st_q inside {BK_IDLE, BK_ACTIVE}));
   // R5: a precharging bank only ever ends in idle
   a_r5_prechg_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == BK_PRECHG) |=> (st_q inside {BK_PRECHG, BK_IDLE}));
endmodule

// File: rtl/ddr_dev_fsm.sv
`timescale 1ns/1ps
module ddr_dev_fsm
   import ddr_cmd_pkg::*;
#(
   parameter  int MRD_CYC = 2,
   parameter  int RFC_CYC = 6,
   localparam int TMAX    = (MRD_CYC > RFC_CYC) ? MRD_CYC : RFC_CYC,
   localparam int TW      = $clog2(TMAX + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mode_i,
   input  logic ref_i,
   input  logic pd_i,
   input  logic wake_i,
   output dev_e dev_o
);
   dev_e dev_q, dev_d;
   logic [TW-1:0] t_q, t_d;

   generate
      if (MRD_CYC < 1 || RFC_CYC < 1) begin : g_bad_cyc
         $error("ddr_dev_fsm: cycle counts must be at least 1");
      end
   endgenerate

   always_comb begin
      dev_d = dev_q;
      t_d   = t_q;
      if (dev_q inside {DV_MODESET, DV_REFRESH}) begin
         if (t_q == '0) dev_d = DV_NORMAL;
         else           t_d   = t_q - 1'b1;
      end
      if (mode_i) begin
         dev_d = DV_MODESET;
         t_d   = TW'(MRD_CYC - 1);
      end else if (ref_i) begin
         dev_d = DV_REFRESH;
         t_d   = TW'(RFC_CYC - 1);
      end else if (pd_i) begin
         dev_d = DV_PWRDN;
      end else if (wake_i) begin
         dev_d = DV_NORMAL;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dev_q <= DV_NORMAL;
         t_q   <= '0;
      end else begin
         dev_q <= dev_d;
         t_q   <= t_d;
      end
   end

   assign dev_o = dev_q;

   // R10: power-down is left only to normal
   a_r10_pd_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_q == DV_PWRDN) |=> (dev_q inside {DV_PWRDN, DV_NORMAL}));
endmodule

// File: rtl/ddr_cmd_tracker.sv
`timescale 1ns/1ps
module ddr_cmd_tracker
   import ddr_cmd_pkg::*;
#(
   parameter  int BANKS     = 4,
   parameter  int BURST_CYC = 4,
   parameter  int PRE_CYC   = 3,
   parameter  int MRD_CYC   = 2,
   parameter  int RFC_CYC   = 6,
   localparam int BA_W      = $clog2(BANKS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cke,
   input  logic               cs_n,
   input  logic               ras_n,
   input  logic               cas_n,
   input  logic               we_n,
   input  logic [BA_W-1:0]    ba,
   input  logic               a10,
   output logic [3:0]         cmd_o,
   output logic               illegal_o,
   output logic [3*BANKS-1:0] bank_state_o,
   output logic [1:0]         dev_state_o
);
   generate
      if (BANKS < 2 || (1 << BA_W) != BANKS) begin : g_bad_banks
         $error("ddr_cmd_tracker: BANKS must be a power of two, at least 2");
      end
   endgenerate

   cmd_e  dec_cmd, cmd_q;
   bank_e bst [BANKS];
   dev_e  dev;
   logic  legal, ill_q, cke_q;
   logic  [BANKS-1:0] bursting, idle_v;

   ddr_cmd_decode u_dec (
      .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .cke(cke), .ba0(ba[0]), .a10(a10),
      .pd_i(dev == DV_PWRDN), .cmd_o(dec_cmd));

   ddr_cmd_judge #(.BANKS(BANKS)) u_judge (
      .cmd_i(dec_cmd), .ba_i(ba), .st_i(bst), .dev_i(dev),
      .cke_prev_i(cke_q), .legal_o(legal));

   generate
      for (genvar g = 0; g < BANKS; g++) begin : g_bank
         logic sel;
         assign sel = (ba == BA_W'(g));
         ddr_bank_fsm #(.BURST_CYC(BURST_CYC), .PRE_CYC(PRE_CYC)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .act_i(legal && dec_cmd == CMD_ACT   && sel),
            .rd_i (legal && dec_cmd == CMD_READ  && sel),
            .wr_i (legal && dec_cmd == CMD_WRITE && sel),
            .pre_i(legal && (dec_cmd == CMD_PREALL || (dec_cmd == CMD_PRE && sel))),
            .end_i(legal && (dec_cmd == CMD_BSTOP ||
                             ((dec_cmd inside {CMD_READ, CMD_WRITE}) && !sel))),
            .st_o (bst[g]));
         assign bank_state_o[3*g +: 3] = bst[g];
         assign bursting[g] = (bst[g] inside {BK_READING, BK_WRITING});
         assign idle_v[g]   = (bst[g] == BK_IDLE);
      end
   endgenerate

   ddr_dev_fsm #(.MRD_CYC(MRD_CYC), .RFC_CYC(RFC_CYC)) u_dev (
      .clk(clk), .rst_n(rst_n),
      .mode_i(legal && (dec_cmd inside {CMD_MODE, CMD_EXTMODE})),
      .ref_i (legal && dec_cmd == CMD_REFRESH),
      .pd_i  (legal && dec_cmd == CMD_PDENTER),
      .wake_i(legal && dec_cmd == CMD_PDEXIT),
      .dev_o (dev));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cke_q <= 1'b0;
         cmd_q <= CMD_NOP;
         ill_q <= 1'b0;
      end else begin
         cke_q <= cke;
         cmd_q <= dec_cmd;
         ill_q <= !legal;
      end
   end

   assign cmd_o       = cmd_q;
   assign illegal_o   = ill_q;
   assign dev_state_o = dev;

   // R7: never two bursts at once
   a_r7_single_burst: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bursting));
   // R10: power-down only with every bank closed
   a_r10_pd_all_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (dev == DV_PWRDN) |-> (&idle_v));
   // R8: refresh only with every bank closed
   a_r8_ref_all_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (dev == DV_REFRESH) |-> (&idle_v));
   // R6: mode write only with every bank closed
   a_r6_mode_all_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (dev == DV_MODESET) |-> (&idle_v));
endmodule

// File: tb/sim_ddr_cmd_tracker.sv
`timescale 1ns/1ps
module sim_ddr_cmd_tracker;
   localparam logic [3:0] C_NOP = 4'b0111, C_DES = 4'b1000, C_ACT = 4'b0011,
                          C_RD  = 4'b0101, C_WR  = 4'b0100, C_PRE = 4'b0010,
                          C_REF = 4'b0001, C_MRS = 4'b0000, C_BST = 4'b0110;
   localparam logic [2:0] I = 3'd0, A = 3'd1, R = 3'd2, W = 3'd3, P = 3'd4;
   localparam logic [1:0] DN = 2'd0, DM = 2'd1, DF = 2'd2, DD = 2'd3;

   typedef struct packed {
      logic [3:0]  ctl;
      logic        cke;
      logic [1:0]  ba;
      logic        a10;
      logic [3:0]  cmd;
      logic        ill;
      logic [11:0] bk;
      logic [1:0]  dev;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 38;
   localparam vec_t TBL [NV] = '{
      '{C_MRS,1'b1,2'd0,1'b0,4'd8, 1'b1,{I,I,I,I},DN,4'd6},  // R6 CKE not high before
      '{C_MRS,1'b1,2'd0,1'b0,4'd8, 1'b0,{I,I,I,I},DM,4'd6},  // R6
      '{C_ACT,1'b1,2'd0,1'b0,4'd2, 1'b1,{I,I,I,I},DM,4'd12}, // R12 busy device
      '{C_NOP,1'b1,2'd0,1'b0,4'd0, 1'b0,{I,I,I,I},DN,4'd12}, // R12 single pulse
      '{C_MRS,1'b1,2'd1,1'b0,4'd9, 1'b0,{I,I,I,I},DM,4'd2},  // R2 extended
      '{C_NOP,1'b1,2'd0,1'b0,4'd0, 1'b0,{I,I,I,I},DM,4'd6},
      '{C_NOP,1'b1,2'd0,1'b0,4'd0, 1'b0,{I,I,I,I},DN,4'd6},
      '{C_ACT,1'b1,2'd0,1'b0,4'd2, 1'b0,{I,I,I,A},DN,4'd3},  // R3
      '{C_ACT,1'b1,2'd0,1'b0,4'd2, 1'b1,{I,I,I,A},DN,4'd3},  // R3 bank open
      '{C_RD, 1'b1,2'd1,1'b0,4'd3, 1'b1,{I,I,I,A},DN,4'd4},  // R4 closed bank
      '{C_RD, 1'b1,2'd0,1'b0,4'd3, 1'b0,{I,I,I,R},DN,4'd4},  // R4
      '{C_NOP,1'b1,2'd0,1'b0,4'd0, 1'b0,{I,I,I,R},DN,4'd11}, // R11
      '{C_BST,1'b1,2'd0,1'b0,4'd10,1'b0,{I,I,I,A},DN,4'd9},  // R9
      '{C_BST,1'b1,2'd0,1'b0,4'd10,1'b1,{I,I,I,A},DN,4'd9},  // R9 no read
      '{C_ACT,1'b1,2'd2,1'b0,4'd2, 1'b0,{I,A,I,A},DN,4'd3},
      '{C_WR, 1'b1,2'd2,1'b0,4'd4, 1'b0,{I,W,I,A},DN,4'd4},
      '{C_BST,1'b1,2'd0,1'b0,4'd10,1'b1,{I,W,I,A},DN,4'd9},  // R9 during write
      '{C_RD, 1'b1,2'd0,1'b0,4'd3, 1'b0,{I,A,I,R},DN,4'd7},  // R7
      '{C_DES,1'b1,2'd0,1'b0,4'd1, 1'b0,{I,A,I,R},DN,4'd11}, // R11
      '{C_NOP,1'b1,2'd0,1'b0,4'd0, 1'b0,{I,A,I,R},DN,4'd4},
      '{C_NOP,1'b1,2'd0,1'b0,4'd0, 1'b0,{I,A,I,R},DN,4'd4},
      '{C_NOP,1'b1,2'd0,1'b0,4'd0, 1'b0,{I,A,I,A},DN,4'd4},  // R4 burst length
      '{C_REF,1'b1,2'd0,1'b0,4'd7, 1'b1,{I,A,I,A},DN,4'd8},  // R8 open banks
      '{C_PRE,1'b1,2'd0,1'b0,4'd5, 1'b0,{I,A,I,P},DN,4'd5},  // R5
      '{C_PRE,1'b1,2'd0,1'b1,4'd6, 1'b0,{I,P,I,P},DN,4'd5},  // R5 all banks
      '{C_NOP,1'b1,2'd0,1'b0,4'd0, 1'b0,{I,P,I,P},DN,4'd5},
      '{C_NOP,1'b1,2'd0,1'b0,4'd0, 1'b0,{I,P,I,I},DN,4'd5},
      '{C_NOP,1'b0,2'd0,1'b0,4'd11,1'b1,{I,I,I,I},DN,4'd10}, // R10 last precharge edge
      '{C_NOP,1'b0,2'd0,1'b0,4'd11,1'b0,{I,I,I,I},DD,4'd10},
      '{C_ACT,1'b0,2'd0,1'b0,4'd0, 1'b0,{I,I,I,I},DD,4'd10}, // R10 ignored
      '{C_NOP,1'b1,2'd0,1'b0,4'd12,1'b0,{I,I,I,I},DN,4'd10},
      '{C_REF,1'b1,2'd0,1'b0,4'd7, 1'b0,{I,I,I,I},DF,4'd8},  // R8
      '{C_RD, 1'b1,2'd0,1'b0,4'd3, 1'b1,{I,I,I,I},DF,4'd12},
      '{C_NOP,1'b1,2'd0,1'b0,4'd0, 1'b0,{I,I,I,I},DF,4'd8},
      '{C_NOP,1'b1,2'd0,1'b0,4'd0, 1'b0,{I,I,I,I},DF,4'd8},
      '{C_NOP,1'b1,2'd0,1'b0,4'd0, 1'b0,{I,I,I,I},DF,4'd8},
      '{C_NOP,1'b1,2'd0,1'b0,4'd0, 1'b0,{I,I,I,I},DF,4'd8},
      '{C_NOP,1'b1,2'd0,1'b0,4'd0, 1'b0,{I,I,I,I},DN,4'd8}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic cke, cs_n, ras_n, cas_n, we_n, a10;
   logic [1:0] ba;
   logic [3:0] cmd_o;
   logic illegal_o;
   logic [11:0] bank_state_o;
   logic [1:0] dev_state_o;
   int checks = 0, errors = 0;

   always #2.5 clk = ~clk;

   ddr_cmd_tracker u0 (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10), .cmd_o(cmd_o),
      .illegal_o(illegal_o), .bank_state_o(bank_state_o), .dev_state_o(dev_state_o));

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic drive(input logic [3:0] ctl, input logic k, input logic [1:0] b, input logic a);
      {cs_n, ras_n, cas_n, we_n} = ctl;
      cke = k; ba = b; a10 = a;
   endtask

   task automatic step_chk(input string tag, input int cmd, input int ill, input int bk, input int dev);
      @(posedge clk); @(negedge clk);
      chk(tag, "cmd", int'(cmd_o), cmd);
      chk(tag, "illegal", int'(illegal_o), ill);
      chk(tag, "banks", int'(bank_state_o), bk);
      chk(tag, "dev", int'(dev_state_o), dev);
   endtask

   initial begin
      #(5.0 * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      drive(C_NOP, 1'b1, 2'd0, 1'b0);
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "cmd", int'(cmd_o), 0);
      chk("R1", "illegal", int'(illegal_o), 0);
      chk("R1", "banks", int'(bank_state_o), 0);
      chk("R1", "dev", int'(dev_state_o), 0);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         drive(TBL[i].ctl, TBL[i].cke, TBL[i].ba, TBL[i].a10);
         step_chk($sformatf("R%0d vec%0d", TBL[i].req, i),
                  TBL[i].cmd, TBL[i].ill, TBL[i].bk, TBL[i].dev);
      end
      // R1: reset in the middle of an open row
      drive(C_ACT, 1'b1, 2'd3, 1'b0);
      step_chk("R3 bank3", 2, 0, {A, I, I, I}, DN);
      drive(C_NOP, 1'b1, 2'd0, 1'b0);
      rst_n = 1'b0;
      step_chk("R1 mid-op reset", 0, 0, 0, DN);
      rst_n = 1'b1;
      // R10 then R1: reset leaves power-down
      drive(C_NOP, 1'b0, 2'd0, 1'b0);
      step_chk("R10 entry", 11, 0, 0, DD);
      rst_n = 1'b0;
      step_chk("R1 pd cleared", 0, 0, 0, DN);
      rst_n = 1'b1;
      drive(C_NOP, 1'b1, 2'd0, 1'b0);
      step_chk("R11 nop", 0, 0, 0, DN);
      // R4: write burst length on bank 1
      drive(C_ACT, 1'b1, 2'd1, 1'b0);
      step_chk("R3 bank1", 2, 0, {I, I, A, I}, DN);
      drive(C_WR, 1'b1, 2'd1, 1'b0);
      step_chk("R4 write", 4, 0, {I, I, W, I}, DN);
      drive(C_NOP, 1'b1, 2'd0, 1'b0);
      for (int k = 0; k < 3; k++) step_chk("R4 write hold", 0, 0, {I, I, W, I}, DN);
      step_chk("R4 write done", 0, 0, {I, I, A, I}, DN);
      // R5: precharge of an idle bank leaves it idle
      drive(C_PRE, 1'b1, 2'd2, 1'b0);
      step_chk("R5 idle bank", 5, 0, {I, I, A, I}, DN);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule